// File: doc/BRIEF.md
# Serial Converter Output Port Model

This block is a synthesizable stand-in for the digital serial read-out side of a 16-bit converter whose data leaves under an external data clock. A host lowers the read/convert line while the chip select is low to begin a conversion. The conversion time is modelled by a programmable cycle count. The value the conversion will produce is taken from a parallel test port at the moment the conversion starts. While the conversion runs, BUSY is low. When the count expires, the new value becomes the stored result.

A read is open while chip select is low and read/convert is high. On each rising data-clock edge the block drives the next bit of the stored result, most significant bit first. A one-slot SYNC lead-in comes first when it was armed beforehand. After the last word bit, the DATA pin replays the TAG input delayed by one word length, which lets several parts form a daisy chain. Any data-clock edge seen while chip select is high, or while both chip select and read/convert are low, arms the lead-in for the next read.

All of the pins (data clock, chip select, read/convert, tag) pass through two-flop synchronizers into one fast system clock. Edges are detected in that clock domain, and every output is a register in it.

The conversion controller has two states. In CV_IDLE, BUSY is high. The transition CV_IDLE->CV_RUN happens on an accepted start. The transition CV_RUN->CV_IDLE happens when the count expires. The read machine has five states:
- RD_IDLE: no read is open.
- RD_PRE: a read is open and no edge has arrived yet.
- RD_SYNC: the lead-in slot.
- RD_WORD: the word bits.
- RD_TAG: the tag replay.

Its transitions are:
- RD_IDLE->RD_PRE when a read opens.
- RD_PRE->RD_SYNC on the first rising edge if the lead-in is armed.
- RD_PRE->RD_WORD or RD_SYNC->RD_WORD on the next rising edge.
- RD_WORD->RD_TAG after the last bit.
- Any state ->RD_IDLE when the read closes.

Top module: `serial_adc_port`

## Requirements
- R1: After reset, busy is 1, data_out is 0 and sync_out is 0.
- R2: A falling read/convert level while chip select is low starts a conversion. busy then reads 0 and returns to 1 after CONV_CYCLES system cycles.
- R3: Lowering read/convert while chip select is high starts no conversion, so busy stays 1.
- R4: With no lead-in armed, the word bit of rank k (MSB is k=1) is driven after rising data-clock edge k, for k=1..16.
- R5: A data-clock edge while chip select is high arms the lead-in. The next read then drives sync_out=1 with data_out=0 after rising edge 1, and drives word bit k after rising edge k+1.
- R6: sync_out is 1 for the lead-in slot only. Issuing the lead-in disarms it, so the following read with no new qualifying edge has no lead-in.
- R7: A read opened while busy is 0 returns the previous result. A read opened after busy returns to 1 returns the value loaded at the start of that conversion.
- R8: After the word, data_out shows the tag value sampled 16 rising edges earlier. The first replayed value is the tag at rising edge 1 without a lead-in, and at rising edge 2 with one.
- R9: While chip select is high, data_out and sync_out are 0.
- R10: A conversion start that coincides with no data-clock edge disarms a previously armed lead-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the data clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rc | input | 1 | Read/convert: low starts a conversion, high permits a read |
| dclk | input | 1 | External data clock |
| tag_in | input | 1 | Daisy-chain input, sampled on rising data-clock edges |
| load_word | input | WORD_W | Test-port value taken as the result of a conversion at its start |
| busy | output | 1 | Low while a conversion runs |
| data_out | output | 1 | Serial word bits, then replayed tag values |
| sync_out | output | 1 | One-slot lead-in pulse before the word |

## Verification
Frames are read both with and without a lead-in. Across the two, the bench tells whether the word is offset by exactly one slot and whether the tag replay in lead-in mode skips the value sampled at rising edge 1. Tag patterns with distinct bits in every position expose an off-by-one in the replay delay. Words with mixed bit patterns expose a reversed or shifted bit order. Reads opened during and after a conversion tell the stored result apart from the pending one. Arming followed by a conversion with no clock edges separates the R10 disarm from the R6 disarm.

// File: rtl/serial_adc_pkg.sv
package serial_adc_pkg;
    typedef enum logic [2:0] {
        RD_IDLE,
        RD_PRE,
        RD_SYNC,
        RD_WORD,
        RD_TAG
    } rd_state_e;

    typedef enum logic {
        CV_IDLE,
        CV_RUN
    } cv_state_e;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1_q;
        logic s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[i];
                s2_q <= RST_VAL[i];
            end else begin
                s1_q <= din[i];
                s2_q <= s1_q;
            end
        end
        assign dout[i] = s2_q;
    end
endmodule

// File: rtl/sadc_conv.sv
module sadc_conv
    import serial_adc_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CONV_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [WORD_W-1:0] load_word,
    output logic              conv_start,
    output logic              busy,
    output logic [WORD_W-1:0] result
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    cv_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [WORD_W-1:0] pend_q;

    assign conv_start = start_req && (st_q == CV_IDLE);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CV_IDLE: if (start_req) st_d = CV_RUN;
            CV_RUN:  if (cnt_q == LAST) st_d = CV_IDLE;
            default: st_d = CV_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CV_IDLE;
        else        st_q <= st_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= '0;
            result <= '0;
            busy   <= 1'b1;
        end else begin
            busy <= (st_d == CV_IDLE);
            if (conv_start) begin
                pend_q <= load_word;
                cnt_q  <= '0;
            end else if (st_q == CV_RUN) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) result <= pend_q;
            end
        end
    end
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
    import serial_adc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              read_en,
    input  logic              dclk_rise,
    input  logic              qual_edge,
    input  logic              conv_start,
    input  logic              tag_s,
    input  logic [WORD_W-1:0] word_in,
    output logic              data_out,
    output logic              sync_out,
    output logic              arm_q
);
    localparam int CNT_W = $clog2(WORD_W + 3);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(WORD_W + 2);

    rd_state_e         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc, slot;
    logic [WORD_W-1:0] wsr_q, wsr_d, tsr_q, tsr_d;
    logic              mode_q, mode_d, data_d, sync_d, issue;

    assign cnt_inc = (cnt_q == SAT) ? cnt_q : cnt_q + 1'b1;
    assign slot    = cnt_inc - CNT_W'(1) - CNT_W'(mode_q);

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        wsr_d  = wsr_q;
        tsr_d  = tsr_q;
        mode_d = mode_q;
        data_d = data_out;
        sync_d = sync_out;
        issue  = 1'b0;
        if (!read_en) begin
            st_d   = RD_IDLE;
            data_d = 1'b0;
            sync_d = 1'b0;
        end else begin
            unique case (st_q)
                RD_IDLE: begin
                    st_d   = RD_PRE;
                    wsr_d  = word_in;
                    mode_d = arm_q;
                    cnt_d  = '0;
                    data_d = 1'b0;
                    sync_d = 1'b0;
                end
                RD_PRE, RD_SYNC, RD_WORD, RD_TAG: begin
                    if (dclk_rise) begin
                        cnt_d = cnt_inc;
                        tsr_d = {tsr_q[WORD_W-2:0], tag_s};
                        if (mode_q && cnt_inc == CNT_W'(1)) begin
                            st_d   = RD_SYNC;
                            sync_d = 1'b1;
                            data_d = 1'b0;
                            issue  = 1'b1;
                        end else if (slot < CNT_W'(WORD_W)) begin
                            st_d   = RD_WORD;
                            sync_d = 1'b0;
                            data_d = wsr_q[WORD_W-1];
                            wsr_d  = {wsr_q[WORD_W-2:0], 1'b0};
                        end else begin
                            st_d   = RD_TAG;
                            sync_d = 1'b0;
                            data_d = tsr_q[WORD_W-1];
                        end
                    end
                end
                default: st_d = RD_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RD_IDLE;
        else        st_q <= st_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            wsr_q    <= '0;
            tsr_q    <= '0;
            mode_q   <= 1'b0;
            data_out <= 1'b0;
            sync_out <= 1'b0;
            arm_q    <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            wsr_q    <= wsr_d;
            tsr_q    <= tsr_d;
            mode_q   <= mode_d;
            data_out <= data_d;
            sync_out <= sync_d;
            if (qual_edge)                arm_q <= 1'b1;
            else if (issue || conv_start) arm_q <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_adc_port.sv
module serial_adc_port #(
    parameter int WORD_W      = 16,
    parameter int CONV_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rc,
    input  logic              dclk,
    input  logic              tag_in,
    input  logic [WORD_W-1:0] load_word,
    output logic              busy,
    output logic              data_out,
    output logic              sync_out
);
    logic [3:0]        pins_s;
    logic              cs_s, rc_s, dclk_s, tag_s;
    logic              dclk_prev_q, rc_prev_q;
    logic              dclk_rise, dclk_edge, rc_fall;
    logic              qual_edge, start_req, conv_start, read_en, arm_q;
    logic [WORD_W-1:0] result;

    sadc_sync #(.N(4), .RST_VAL(4'b0011)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({tag_in, dclk, rc, cs_n}),
        .dout (pins_s)
    );

    assign cs_s   = pins_s[0];
    assign rc_s   = pins_s[1];
    assign dclk_s = pins_s[2];
    assign tag_s  = pins_s[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dclk_prev_q <= 1'b0;
            rc_prev_q   <= 1'b1;
        end else begin
            dclk_prev_q <= dclk_s;
            rc_prev_q   <= rc_s;
        end
    end

    assign dclk_rise = dclk_s & ~dclk_prev_q;
    assign dclk_edge = dclk_s ^ dclk_prev_q;
    assign rc_fall   = rc_prev_q & ~rc_s;
    assign qual_edge = dclk_edge && (cs_s || !rc_s);
    assign start_req = rc_fall && !cs_s;
    assign read_en   = !cs_s && rc_s;

    sadc_conv #(.WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .load_word (load_word),
        .conv_start(conv_start),
        .busy      (busy),
        .result    (result)
    );

    sadc_reader #(.WORD_W(WORD_W)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .read_en   (read_en),
        .dclk_rise (dclk_rise),
        .qual_edge (qual_edge),
        .conv_start(conv_start),
        .tag_s     (tag_s),
        .word_in   (result),
        .data_out  (data_out),
        .sync_out  (sync_out),
        .arm_q     (arm_q)
    );
endmodule

// File: rtl/serial_adc_port_chk.sv
module serial_adc_port_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic conv_start,
    input logic busy,
    input logic data_out,
    input logic sync_out,
    input logic arm_q
);
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !busy); // R2

    AST_NO_START_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cs_s) |=> busy); // R3

    AST_SYNC_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> $past(arm_q)); // R5

    AST_SYNC_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> !arm_q); // R6

    AST_SYNC_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_out) |=> !sync_out || !$past(arm_q)); // R6

    AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!data_out && !sync_out)); // R9
endmodule

bind serial_adc_port serial_adc_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .conv_start(conv_start),
    .busy      (busy),
    .data_out  (data_out),
    .sync_out  (sync_out),
    .arm_q     (arm_q)
);

// File: tb/serial_adc_port_bench.sv
`timescale 1ns/1ps
module serial_adc_port_bench;
    localparam int W    = 16;
    localparam int CONV = 64;
    localparam int HALF = 10;
    localparam int NP   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rc = 1'b1, dclk = 1'b0, tag_in = 1'b0;
    logic [W-1:0] load_word = '0;
    logic busy, data_out, sync_out;
    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    serial_adc_port #(.WORD_W(W), .CONV_CYCLES(CONV)) u_serial_adc_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc(rc), .dclk(dclk),
        .tag_in(tag_in), .load_word(load_word),
        .busy(busy), .data_out(data_out), .sync_out(sync_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_conv(input logic [W-1:0] w);
        load_word = w;
        cs_n = 1'b0; wt(4);
        rc = 1'b0;   wt(8);
        chk("R2 busy low after start", busy, 1'b0);
        cs_n = 1'b1; wt(4);
        rc = 1'b1;   wt(2);
    endtask

    task automatic arm_edge();
        dclk = 1'b1; wt(HALF);
        chk("R9 data low while deselected", data_out, 1'b0);
        chk("R9 sync low while deselected", sync_out, 1'b0);
        dclk = 1'b0; wt(HALF);
    endtask

    // reference: expected stream = [lead-in] ++ word MSB first ++ tag history
    task automatic read_frame(input logic exp_sync, input logic [W-1:0] w,
                              input logic [NP-1:0] tags, input string req);
        logic tq[$];
        logic ed, es;
        cs_n = 1'b0; wt(4);
        for (int k = 1; k <= NP; k++) begin
            tag_in = tags[k-1]; wt(2);
            dclk = 1'b1; wt(HALF);
            dclk = 1'b0; wt(HALF/2);
            if (!(exp_sync && k == 1)) tq.push_back(tags[k-1]);
            if (exp_sync && k == 1) begin
                es = 1'b1; ed = 1'b0;
            end else begin
                int idx = k - 1 - int'(exp_sync);
                es = 1'b0;
                if (idx < W) ed = w[W-1-idx];
                else         ed = tq.pop_front();
            end
            chk($sformatf("%s data pulse %0d", req, k), data_out, ed);
            chk($sformatf("%s sync pulse %0d", req, k), sync_out, es);
            wt(HALF - HALF/2);
        end
        cs_n = 1'b1; wt(6);
        chk("R9 data low after deselect", data_out, 1'b0);
        chk("R9 sync low after deselect", sync_out, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wt(5); rst_n = 1'b1; wt(2);
        chk("R1 busy after reset", busy, 1'b1);
        chk("R1 data after reset", data_out, 1'b0);
        chk("R1 sync after reset", sync_out, 1'b0);

        // R3: read/convert low while deselected
        rc = 1'b0; wt(12);
        chk("R3 no start while deselected", busy, 1'b1);
        rc = 1'b1; wt(4);

        // R2: conversion length
        start_conv(16'hA5C3);
        wt(CONV/2 - 20);
        chk("R2 busy low mid conversion", busy, 1'b0);
        wt(CONV/2 + 12);
        chk("R2 busy high after conversion", busy, 1'b1);

        // R4 R7 R8: plain read after completion
        read_frame(1'b0, 16'hA5C3, 20'hB3E5A, "R4 R7 R8 plain");

        // R5 R8: armed read
        arm_edge();
        read_frame(1'b1, 16'hA5C3, 20'h6D2C7, "R5 R8 lead-in");

        // R6: disarmed after issue
        read_frame(1'b0, 16'hA5C3, 20'h0F0F3, "R6 no repeat");

        // R7: read during busy returns previous result
        start_conv(16'h3C96);
        chk("R7 busy low at read open", busy, 1'b0);
        read_frame(1'b0, 16'hA5C3, 20'h95A3C, "R7 during busy");
        chk("R7 busy high after", busy, 1'b1);
        read_frame(1'b0, 16'h3C96, 20'h5A5A5, "R7 after busy");

        // R10: start without edge disarms
        arm_edge();
        start_conv(16'h0FF1);
        wt(CONV + 10);
        read_frame(1'b0, 16'h0FF1, 20'hC1E3D, "R10 disarm on start");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule